// File: doc/BRIEF.md
# Suspend-Mode Display Memory Refresh Controller

This block governs the hardware suspend state of a display controller whose frame memory is DRAM. While suspend is requested, it stops display fetches, CPU traffic to memory, register and colour-table accesses, and the sequencer. It also turns panel power off and parks the panel interface. Throughout suspend it keeps the DRAM alive by issuing refresh requests to the DRAM controller, or by placing the DRAM in self-refresh.

There are three timebases for refresh. The first is the system clock divided down by a build-time ratio. The second is a slow 32 kHz square-wave pin, where both edges count. The third is a pin that carries short active-low pulses at 64 kHz. The resulting event stream is either used directly or divided by eight, which gives the slow refresh rate. The panel parking style comes from a strap bit that is captured while reset is held. On suspend exit, the inhibits stay asserted until any outstanding refresh request has been acknowledged.

Top module: `susp_refresh_ctrl`

## Requirements
- R1: With `cfg_src_i` = 0 and suspend active, a refresh event occurs once every `DIV_RATIO` system clock cycles, counted from suspend entry.
- R2: With `cfg_src_i` = 1, every transition of `slow_clk_i` (rising and falling) is one refresh event.
- R3: With `cfg_src_i` = 2, every high-to-low transition of `strobe_n_i` is one refresh event. Code 3 selects no source.
- R4: With `cfg_rate_i` = 0, every event produces a request. With `cfg_rate_i` = 1, only every eighth event since suspend entry produces one.
- R5: `ref_req_o` rises once per granted event, stays high until `ref_ack_i` is seen, and never rises outside suspend.
- R6: With `cfg_self_ref_i` = 1, `self_refresh_o` is high while suspended and no refresh request is raised.
- R7: One cycle after `suspend_i` is sampled high, `fetch_block_o`, `cpu_mem_block_o`, `reg_block_o`, `seq_halt_o` and `cpu_in_mask_o` are all high.
- R8: `panel_pwr_n_o` is high (power off) while suspended and low otherwise.
- R9: The strap `strap_park_low_i` is captured while `rst_n` is low. With strap 0, suspend drives `panel_oe_o` low (high impedance). With strap 1, suspend drives `panel_drive_low_o` high and keeps `panel_oe_o` high. Changes to the strap after reset have no effect.
- R10: `int_clk_en_o` is low while suspended unless `cfg_src_i` = 0. It is high outside suspend.
- R11: After `suspend_i` falls, the inhibits stay high until a pending refresh request has been acknowledged.
- R12: After reset, all inhibits and requests are low, `panel_pwr_n_o` is low, `panel_oe_o` is high and `int_clk_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk_i | input | 1 | Asynchronous 32 kHz square-wave timebase |
| strobe_n_i | input | 1 | Asynchronous 64 kHz active-low pulse timebase |
| suspend_i | input | 1 | Suspend request |
| strap_park_low_i | input | 1 | Panel parking strap, captured during reset |
| cfg_src_i | input | 2 | Refresh source: 0 divided clock, 1 slow clock, 2 strobe, 3 none |
| cfg_rate_i | input | 1 | 0 full event rate, 1 one-in-eight |
| cfg_self_ref_i | input | 1 | Use DRAM self-refresh instead of requests |
| ref_ack_i | input | 1 | Refresh acknowledge from DRAM controller |
| ref_req_o | output | 1 | Refresh request, held until acknowledged |
| self_refresh_o | output | 1 | Self-refresh enable to DRAM controller |
| fetch_block_o | output | 1 | Block display fetches |
| cpu_mem_block_o | output | 1 | Block CPU memory reads and writes |
| reg_block_o | output | 1 | Reject register and colour-table accesses |
| seq_halt_o | output | 1 | Halt the sequencer |
| cpu_in_mask_o | output | 1 | Mask CPU inputs and idle CPU outputs |
| int_clk_en_o | output | 1 | Enable for the gated internal clock |
| panel_pwr_n_o | output | 1 | Active-low panel power enable |
| panel_oe_o | output | 1 | Panel output enable (low means high impedance) |
| panel_drive_low_o | output | 1 | Force panel outputs to logic low |

## Verification
The bound checker watches several rules on every cycle. A request holds until acknowledged and never starts outside suspend or in self-refresh. Every new request is traced back to a granted refresh event. The inhibits never drop while a request is outstanding. Panel power and the panel parking mode agree with the suspend state and the captured strap, and the internal clock is gated only when it is not the timebase. The bench scenarios cover the parts that need counting over many cycles: request counts per source, the one-in-eight divider, strap capture across two resets, and the drain wait on exit.

// File: rtl/susp_ref_pkg.sv
package susp_ref_pkg;

  typedef enum logic [1:0] {
    SRC_SYSDIV  = 2'd0,
    SRC_SLOWCLK = 2'd1,
    SRC_STROBE  = 2'd2,
    SRC_NONE    = 2'd3
  } ref_src_e;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_SUSP  = 2'd1,
    PH_DRAIN = 2'd2
  } susp_phase_e;

  localparam int unsigned SLOW_RATE_DIV = 8;

  // last count of the system-clock divider
  function automatic logic div_wrap(input int unsigned cnt, input int unsigned ratio);
    return cnt == ratio - 1;
  endfunction

  // whether an event at the current event count yields a request
  function automatic logic rate_fire(input logic slow_rate, input int unsigned cnt);
    return !slow_rate || (cnt == SLOW_RATE_DIV - 1);
  endfunction

endpackage

// File: rtl/sr_pin_sync.sv
module sr_pin_sync #(
  parameter int unsigned STAGES    = 2,
  parameter int unsigned EDGE_MODE = 0,  // 0 rising, 1 falling, 2 both
  parameter logic        IDLE      = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic edge_o
);
  localparam int unsigned W = STAGES + 1;

  logic [W-1:0] chain;
  logic         lvl, prev, rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {W{IDLE}};
    else        chain <= {chain[W-2:0], pin_i};
  end

  assign lvl  = chain[STAGES-1];
  assign prev = chain[STAGES];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  generate
    if (EDGE_MODE == 2) begin : g_both
      assign edge_o = rise | fall;
    end else if (EDGE_MODE == 1) begin : g_fall
      assign edge_o = fall;
    end else begin : g_rise
      assign edge_o = rise;
    end
  endgenerate
endmodule

// File: rtl/sr_tick_gen.sv
module sr_tick_gen
  import susp_ref_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 3125
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_i,
  input  ref_src_e src_i,
  input  logic     slow_rate_i,
  input  logic     slow_edge_i,
  input  logic     strobe_fall_i,
  output logic     base_tick_o,
  output logic     ref_tick_o
);
  localparam int unsigned CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

  logic [CW-1:0] div_cnt;
  logic [2:0]    rate_cnt;
  logic          div_active, div_hit;

  assign div_active = run_i && (src_i == SRC_SYSDIV);
  assign div_hit    = div_active && div_wrap(32'(div_cnt), DIV_RATIO);

  always_ff @(posedge clk) begin
    if (!rst_n || !div_active) div_cnt <= '0;
    else if (div_hit)          div_cnt <= '0;
    else                       div_cnt <= div_cnt + 1'b1;
  end

  always_comb begin
    base_tick_o = 1'b0;
    if (run_i) begin
      unique case (src_i)
        SRC_SYSDIV:  base_tick_o = div_hit;
        SRC_SLOWCLK: base_tick_o = slow_edge_i;
        SRC_STROBE:  base_tick_o = strobe_fall_i;
        default:     base_tick_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) rate_cnt <= '0;
    else if (base_tick_o) rate_cnt <= rate_cnt + 1'b1;
  end

  assign ref_tick_o = base_tick_o && rate_fire(slow_rate_i, 32'(rate_cnt));
endmodule

// File: rtl/sr_req_ctrl.sv
module sr_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ack_i,
  output logic req_o,
  output logic req_next_o
);
  always_comb begin
    if (req_o) req_next_o = !ack_i;
    else       req_next_o = tick_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= req_next_o;
  end
endmodule

// File: rtl/susp_refresh_ctrl.sv
module susp_refresh_ctrl
  import susp_ref_pkg::*;
#(
  parameter int unsigned DIV_RATIO   = 3125,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_clk_i,
  input  logic       strobe_n_i,
  input  logic       suspend_i,
  input  logic       strap_park_low_i,
  input  logic [1:0] cfg_src_i,
  input  logic       cfg_rate_i,
  input  logic       cfg_self_ref_i,
  input  logic       ref_ack_i,
  output logic       ref_req_o,
  output logic       self_refresh_o,
  output logic       fetch_block_o,
  output logic       cpu_mem_block_o,
  output logic       reg_block_o,
  output logic       seq_halt_o,
  output logic       cpu_in_mask_o,
  output logic       int_clk_en_o,
  output logic       panel_pwr_n_o,
  output logic       panel_oe_o,
  output logic       panel_drive_low_o
);
  ref_src_e    src;
  susp_phase_e phase, phase_nx;
  logic        strap_q;
  logic        in_susp, refresh_run;
  logic        slow_edge, strobe_fall;
  logic        base_tick, ref_tick, granted_tick;
  logic        req_next;

  assign src = ref_src_e'(cfg_src_i);

  // strap sampled on every reset cycle, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_park_low_i;
  end

  sr_pin_sync #(.STAGES(SYNC_STAGES), .EDGE_MODE(2), .IDLE(1'b0)) u_slow_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(slow_clk_i), .edge_o(slow_edge));

  sr_pin_sync #(.STAGES(SYNC_STAGES), .EDGE_MODE(1), .IDLE(1'b1)) u_strobe_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(strobe_n_i), .edge_o(strobe_fall));

  assign refresh_run = (phase == PH_SUSP);
  assign in_susp     = (phase != PH_RUN);

  sr_tick_gen #(.DIV_RATIO(DIV_RATIO)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(refresh_run), .src_i(src),
    .slow_rate_i(cfg_rate_i), .slow_edge_i(slow_edge),
    .strobe_fall_i(strobe_fall), .base_tick_o(base_tick), .ref_tick_o(ref_tick));

  assign granted_tick = ref_tick && !cfg_self_ref_i;

  sr_req_ctrl u_req (
    .clk(clk), .rst_n(rst_n), .tick_i(granted_tick), .ack_i(ref_ack_i),
    .req_o(ref_req_o), .req_next_o(req_next));

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_RUN:   if (suspend_i) phase_nx = PH_SUSP;
      PH_SUSP:  if (!suspend_i) phase_nx = req_next ? PH_DRAIN : PH_RUN;
      PH_DRAIN: if (suspend_i) phase_nx = PH_SUSP;
                else if (!req_next) phase_nx = PH_RUN;
      default:  phase_nx = PH_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_RUN;
    else        phase <= phase_nx;
  end

  assign self_refresh_o    = refresh_run && cfg_self_ref_i;
  assign fetch_block_o     = in_susp;
  assign cpu_mem_block_o   = in_susp;
  assign reg_block_o       = in_susp;
  assign seq_halt_o        = in_susp;
  assign cpu_in_mask_o     = in_susp;
  assign int_clk_en_o      = !in_susp || (src == SRC_SYSDIV);
  assign panel_pwr_n_o     = in_susp;
  assign panel_oe_o        = !(in_susp && !strap_q);
  assign panel_drive_low_o = in_susp && strap_q;

  // base_tick is used by the checker only
endmodule

// File: rtl/susp_refresh_ctrl_chk.sv
module susp_refresh_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_src_i,
  input logic       cfg_self_ref_i,
  input logic       ref_ack_i,
  input logic       ref_req_o,
  input logic       self_refresh_o,
  input logic       fetch_block_o,
  input logic       cpu_mem_block_o,
  input logic       reg_block_o,
  input logic       seq_halt_o,
  input logic       cpu_in_mask_o,
  input logic       int_clk_en_o,
  input logic       panel_pwr_n_o,
  input logic       panel_oe_o,
  input logic       panel_drive_low_o,
  input logic       strap_q,
  input logic       base_tick,
  input logic       granted_tick
);
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req_o && !ref_ack_i) |=> ref_req_o);

  assert_req_only_in_susp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_req_o) |-> fetch_block_o);

  assert_req_from_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_req_o) |-> $past(granted_tick && base_tick));

  assert_self_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (self_refresh_o && $past(self_refresh_o)) |-> !$rose(ref_req_o));

  assert_drain_before_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fetch_block_o) |-> !ref_req_o);

  assert_inhibits_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_block_o |-> (cpu_mem_block_o && reg_block_o && seq_halt_o && cpu_in_mask_o));

  assert_panel_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
    panel_pwr_n_o == fetch_block_o);

  assert_panel_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!panel_oe_o |-> (panel_pwr_n_o && !strap_q)) and
    (panel_drive_low_o |-> (panel_pwr_n_o && strap_q && panel_oe_o)));

  assert_clk_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !int_clk_en_o |-> (fetch_block_o && cfg_src_i != 2'd0));
endmodule

bind susp_refresh_ctrl susp_refresh_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_src_i(cfg_src_i), .cfg_self_ref_i(cfg_self_ref_i),
  .ref_ack_i(ref_ack_i), .ref_req_o(ref_req_o), .self_refresh_o(self_refresh_o),
  .fetch_block_o(fetch_block_o), .cpu_mem_block_o(cpu_mem_block_o),
  .reg_block_o(reg_block_o), .seq_halt_o(seq_halt_o), .cpu_in_mask_o(cpu_in_mask_o),
  .int_clk_en_o(int_clk_en_o), .panel_pwr_n_o(panel_pwr_n_o), .panel_oe_o(panel_oe_o),
  .panel_drive_low_o(panel_drive_low_o), .strap_q(strap_q), .base_tick(base_tick),
  .granted_tick(granted_tick));

// File: tb/susp_refresh_ctrl_bench.sv
module susp_refresh_ctrl_bench;
  localparam int unsigned DIV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_clk = 1'b0, strobe_n = 1'b1, suspend = 1'b0, strap = 1'b0;
  logic [1:0] src = 2'd0;
  logic rate = 1'b0, self_ref = 1'b0, ack = 1'b0;
  logic req, selfr, fblk, cblk, rblk, halt, cmask, clken, ppwr_n, poe, plow;

  int checks = 0, fails = 0, req_count = 0, cycles = 0;
  logic req_prev = 1'b0;
  logic resp_en = 1'b1;

  always #2.5 clk = ~clk;

  susp_refresh_ctrl #(.DIV_RATIO(DIV)) u_susp_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_clk_i(slow_clk), .strobe_n_i(strobe_n),
    .suspend_i(suspend), .strap_park_low_i(strap), .cfg_src_i(src),
    .cfg_rate_i(rate), .cfg_self_ref_i(self_ref), .ref_ack_i(ack),
    .ref_req_o(req), .self_refresh_o(selfr), .fetch_block_o(fblk),
    .cpu_mem_block_o(cblk), .reg_block_o(rblk), .seq_halt_o(halt),
    .cpu_in_mask_o(cmask), .int_clk_en_o(clken), .panel_pwr_n_o(ppwr_n),
    .panel_oe_o(poe), .panel_drive_low_o(plow));

  // DRAM-controller stand-in: one-cycle acknowledge, request counter
  always @(negedge clk) begin
    if (req && !req_prev) req_count++;
    req_prev = req;
    ack <= resp_en && req && !ack;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected under 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    strap = s; rst_n = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  task automatic enter_susp();
    suspend = 1'b1;
    wait_cyc(6);
    req_count = 0;
  endtask

  task automatic leave_susp();
    suspend = 1'b0;
    wait_cyc(10);
  endtask

  task automatic strobe_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      strobe_n = 1'b0; wait_cyc(3);
      strobe_n = 1'b1; wait_cyc(20);
    end
  endtask

  task automatic t_reset_state();
    check(!req && !fblk && !cblk && !rblk && !halt && !cmask, "R12 idle flags",
          int'({req, fblk, cblk, rblk, halt, cmask}), 0);
    check(!ppwr_n && poe && clken && !plow, "R12 panel/clock", int'({ppwr_n, poe, clken, plow}), 4'b0110);
  endtask

  task automatic t_divider();
    src = 2'd0; rate = 1'b0;
    suspend = 1'b1;
    @(negedge clk);
    req_count = 0;
    check(clken == 1'b1, "R10 clock kept for divider", int'(clken), 1);
    wait_cyc(104);
    suspend = 1'b0;
    wait_cyc(10);
    check(req_count == 10, "R1 divided-clock requests", req_count, 10);
  endtask

  task automatic t_slowclk();
    src = 2'd1; rate = 1'b0;
    enter_susp();
    check(clken == 1'b0, "R10 clock gated", int'(clken), 0);
    for (int i = 0; i < 8; i++) begin
      slow_clk = ~slow_clk; wait_cyc(30);
    end
    check(req_count == 8, "R2 both slow-clock edges", req_count, 8);
    leave_susp();
    check(clken == 1'b1, "R10 clock restored", int'(clken), 1);
  endtask

  task automatic t_strobe();
    src = 2'd2; rate = 1'b0;
    enter_susp();
    strobe_pulses(5);
    check(req_count == 5, "R3 strobe falling edges", req_count, 5);
    leave_susp();
    rate = 1'b1;
    enter_susp();
    strobe_pulses(16);
    check(req_count == 2, "R4 one-in-eight rate", req_count, 2);
    leave_susp();
    rate = 1'b0;
    req_count = 0;
    strobe_pulses(3);
    check(req_count == 0, "R5 no request outside suspend", req_count, 0);
    src = 2'd3;
    enter_susp();
    strobe_pulses(3);
    check(req_count == 0, "R3 code 3 selects nothing", req_count, 0);
    leave_susp();
  endtask

  task automatic t_self_refresh();
    src = 2'd2; rate = 1'b0; self_ref = 1'b1;
    enter_susp();
    check(selfr == 1'b1, "R6 self-refresh on", int'(selfr), 1);
    strobe_pulses(6);
    check(req_count == 0, "R6 no requests in self-refresh", req_count, 0);
    leave_susp();
    check(selfr == 1'b0, "R6 self-refresh off after exit", int'(selfr), 0);
    self_ref = 1'b0;
  endtask

  task automatic t_inhibit_panel();
    src = 2'd0;
    suspend = 1'b1;
    @(posedge clk); #1;
    check(fblk && cblk && rblk && halt && cmask, "R7 inhibits one cycle after request",
          int'({fblk, cblk, rblk, halt, cmask}), 5'b11111);
    check(ppwr_n == 1'b1, "R8 panel power off", int'(ppwr_n), 1);
    check(poe == 1'b0 && plow == 1'b0, "R9 strap 0 gives high impedance", int'({poe, plow}), 0);
    strap = 1'b1;
    wait_cyc(3);
    check(poe == 1'b0 && plow == 1'b0, "R9 late strap change ignored", int'({poe, plow}), 0);
    strap = 1'b0;
    leave_susp();
    check(ppwr_n == 1'b0 && !fblk, "R8 panel power back on", int'({ppwr_n, fblk}), 0);
  endtask

  task automatic t_strap_low();
    do_reset(1'b1);
    strap = 1'b0;
    src = 2'd0;
    enter_susp();
    check(poe == 1'b1 && plow == 1'b1, "R9 strap 1 drives low", int'({poe, plow}), 3);
    leave_susp();
    check(plow == 1'b0 && poe == 1'b1, "R9 panel released", int'({poe, plow}), 2);
  endtask

  task automatic t_drain();
    src = 2'd2; rate = 1'b0;
    resp_en = 1'b0;
    enter_susp();
    strobe_pulses(1);
    check(req == 1'b1, "R5 request held without ack", int'(req), 1);
    suspend = 1'b0;
    wait_cyc(5);
    check(fblk == 1'b1 && req == 1'b1, "R11 inhibits held while draining", int'({fblk, req}), 3);
    resp_en = 1'b1;
    wait_cyc(5);
    check(fblk == 1'b0 && req == 1'b0, "R11 released after ack", int'({fblk, req}), 0);
  endtask

  initial begin
    do_reset(1'b0);
    t_reset_state();
    t_divider();
    t_slowclk();
    t_strobe();
    t_self_refresh();
    t_inhibit_panel();
    t_drain();
    t_strap_low();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule